// File: doc/BRIEF.md
# Multi-Lane Reset Fan-Out Controller

This block turns a set of asynchronous active-low reset requests into clean, domain-local resets for a multi-lane Ethernet subsystem. One request, the root reset, covers every lane and all shared logic. One further request per lane covers only that lane. For each lane the block drives three outputs. The management-register reset is in the configuration clock domain. The datapath reset is in that lane's own datapath clock domain. The transceiver-controller reset is in the configuration clock domain. Two shared outputs are also produced: a reset for shared logic and a transceiver PLL power-down. Both come from the root reset only.

Every reset output asserts asynchronously. It deasserts synchronously after two pieces of logic in its destination domain: a synchronizer chain, then a hold state machine that keeps the reset active for a fixed number of cycles. The reconfiguration logic drives a one-cycle "reconfiguration finished" strobe per lane. A stretch state machine widens that strobe and retriggers the lane's transceiver-controller reset without touching the lane's other resets.

State machines:
- Hold machine (one per destination domain and source): states `HS_HOLD` and `HS_RUN`.
  - Transition *hold-expire*: from `HS_HOLD` to `HS_RUN` when the hold counter reaches `HOLD_CYC-1`.
  - Transition *source-assert*: asynchronous entry into `HS_HOLD` whenever the synchronized source asserts.
- Stretch machine (one per lane): states `SS_IDLE` and `SS_STRETCH`.
  - Transition *strobe-arm*: from `SS_IDLE` to `SS_STRETCH` on a strobe.
  - Transition *strobe-rearm*: stays in `SS_STRETCH` and restarts the count on a strobe while already stretching.
  - Transition *stretch-expire*: from `SS_STRETCH` to `SS_IDLE` when the count reaches `STRETCH_CYC-1`.
  - Transition *lane-clear*: asynchronous return to `SS_IDLE` while the lane's management reset is asserted.

Top module: `rst_fanout_ctrl`

## Requirements
- R1: While `root_rst_n` is 0, every reset output (`shared_rst`, `pll_pd`, and all bits of `lane_cfg_rst`, `lane_dp_rst`, `lane_xcvr_rst`) is 1. No clock edge is needed for this.
- R2: While `lane_rst_n[i]` is 0 and `root_rst_n` is 1, lane i's three outputs are 1. The outputs of every other lane, `shared_rst` and `pll_pd` stay 0.
- R3: After the last asserted source of a reset output releases, the output stays 1 through `SYNC_STAGES+HOLD_CYC-1` rising edges of its own clock and is 0 after edge number `SYNC_STAGES+HOLD_CYC`. Edge 1 is the first edge after the release. This applies to `shared_rst` and `lane_cfg_rst` (clock `cfg_clk`) and to `lane_dp_rst[i]` (clock `dp_clk[i]`). With the defaults, that is 1 after edge 9 and 0 after edge 10.
- R4: A lane's management and datapath resets come from one combined source, the AND of `root_rst_n` and `lane_rst_n[i]`. Either request being 0 asserts both.
- R5: With lane i out of reset, `reconf_done[i]` sampled 1 at a `cfg_clk` edge E sets `lane_xcvr_rst[i]` to 1 after E. The output stays 1 until it falls after edge E+`STRETCH_CYC`, where E is the last such sampled strobe. A strobe during a stretch therefore restarts it.
- R6: A strobe on `reconf_done[i]` changes no `lane_cfg_rst` or `lane_dp_rst` bit, and no `lane_xcvr_rst` bit of another lane.
- R7: `pll_pd` follows `root_rst_n` only. It asserts immediately when the root reset goes to 0 and is 0 after the `SYNC_STAGES`-th `cfg_clk` edge following release. Lane resets never raise it.
- R8: A strobe on `reconf_done[i]` while `lane_cfg_rst[i]` is 1 is ignored. `lane_xcvr_rst[i]` falls together with `lane_cfg_rst[i]` and stays 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration / management clock |
| dp_clk | input | NUM_LANES | Per-lane datapath clock |
| root_rst_n | input | 1 | Asynchronous active-low reset for everything |
| lane_rst_n | input | NUM_LANES | Asynchronous active-low per-lane reset |
| reconf_done | input | NUM_LANES | Per-lane reconfiguration-finished strobe, `cfg_clk` domain |
| shared_rst | output | 1 | Active-high reset for shared logic, `cfg_clk` domain |
| pll_pd | output | 1 | Transceiver PLL power-down, root reset only |
| lane_cfg_rst | output | NUM_LANES | Active-high management-register reset, `cfg_clk` domain |
| lane_dp_rst | output | NUM_LANES | Active-high datapath reset, `dp_clk[i]` domain |
| lane_xcvr_rst | output | NUM_LANES | Active-high transceiver-controller reset, `cfg_clk` domain |

## Verification
A hold machine stuck in `HS_HOLD`, or one that leaves it early, shows up as a reset output that does not fall on edge `SYNC_STAGES+HOLD_CYC` of its own clock. The bench counts edges per domain after each release, so the fault is seen within about ten cycles. A stretch counter with a wrong terminal value, or a retrigger that fails to restart it, changes the width of `lane_xcvr_rst` by at least one cycle. This is visible at the first strobe. Cross-lane leakage, such as wrong generate indexing or a lane reset feeding the PLL power-down, appears as a wrong bit on another lane's outputs within one edge of the disturbing input.

// File: rtl/rstd_pkg.sv
package rstd_pkg;

    typedef enum logic {
        HS_HOLD = 1'b0,
        HS_RUN  = 1'b1
    } hold_state_e;

    typedef enum logic {
        SS_IDLE    = 1'b0,
        SS_STRETCH = 1'b1
    } stretch_state_e;

endpackage

// File: rtl/rstd_sync.sv
// Asynchronous-assert, synchronous-release reset synchronizer chain.
module rstd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b1};
        end
    end

    assign srst_n = chain[STAGES-1];

endmodule

// File: rtl/rstd_hold.sv
// Holds a reset active for HOLD_CYC cycles after its synchronized source releases.
module rstd_hold
    import rstd_pkg::*;
#(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic srst_n,
    output logic rst_o
);

    localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);
    localparam int SW = $clog2(HOLD_CYC + 2) + 1;

    hold_state_e    state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
            state <= HS_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions: hold-expire
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            HS_HOLD: begin
                if (cnt == LAST) begin
                    state_nx = HS_RUN;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            HS_RUN: begin
                state_nx = HS_RUN;
            end
        endcase
    end

    // outputs
    always_comb begin
        rst_o = (state == HS_HOLD);
    end

    // cycles the output has been held since the source released
    logic [SW-1:0] held_cycles;
    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
            held_cycles <= '0;
        end else if (rst_o && (held_cycles != {SW{1'b1}})) begin
            held_cycles <= held_cycles + 1'b1;
        end
    end

    // R3: the reset never drops before the full hold window
    p_hold_len_r3: assert property (@(posedge clk) disable iff (!srst_n)
        $fell(rst_o) |-> (held_cycles >= SW'(HOLD_CYC)))
        else $error("hold window shorter than HOLD_CYC");

endmodule

// File: rtl/rstd_stretch.sv
// Widens a one-cycle reconfiguration strobe into a STRETCH_CYC-cycle pulse.
module rstd_stretch
    import rstd_pkg::*;
#(
    parameter int STRETCH_CYC = 8
) (
    input  logic clk,
    input  logic arst,
    input  logic strobe,
    output logic busy
);

    localparam int CW = (STRETCH_CYC > 2) ? $clog2(STRETCH_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STRETCH_CYC - 1);
    localparam int SW = $clog2(STRETCH_CYC + 2) + 1;

    stretch_state_e state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    // state register; lane-clear
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state <= SS_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions: strobe-arm, strobe-rearm, stretch-expire
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            SS_IDLE: begin
                if (strobe) begin
                    state_nx = SS_STRETCH;
                    cnt_nx   = '0;
                end
            end
            SS_STRETCH: begin
                if (strobe) begin
                    cnt_nx = '0;
                end else if (cnt == LAST) begin
                    state_nx = SS_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        busy = (state == SS_STRETCH);
    end

    // cycles elapsed since the latest strobe
    logic [SW-1:0] since_strobe;
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            since_strobe <= '0;
        end else if (strobe) begin
            since_strobe <= SW'(1);
        end else if (busy && (since_strobe != {SW{1'b1}})) begin
            since_strobe <= since_strobe + 1'b1;
        end
    end

    // R5: a strobe always opens a stretch on the next cycle
    p_strobe_arms_r5: assert property (@(posedge clk) disable iff (arst)
        strobe |=> busy)
        else $error("strobe did not start a stretch");

    // R5: a stretch never ends early
    p_stretch_len_r5: assert property (@(posedge clk) disable iff (arst)
        $fell(busy) |-> (since_strobe >= SW'(STRETCH_CYC)))
        else $error("stretch shorter than STRETCH_CYC");

endmodule

// File: rtl/rst_fanout_ctrl.sv
// Multi-lane reset fan-out: root and lane requests to per-domain resets.
module rst_fanout_ctrl #(
    parameter int NUM_LANES   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 8,
    parameter int STRETCH_CYC = 8
) (
    input  logic                 cfg_clk,
    input  logic [NUM_LANES-1:0] dp_clk,
    input  logic                 root_rst_n,
    input  logic [NUM_LANES-1:0] lane_rst_n,
    input  logic [NUM_LANES-1:0] reconf_done,
    output logic                 shared_rst,
    output logic                 pll_pd,
    output logic [NUM_LANES-1:0] lane_cfg_rst,
    output logic [NUM_LANES-1:0] lane_dp_rst,
    output logic [NUM_LANES-1:0] lane_xcvr_rst
);

    // shared domain: root request only
    logic root_srst_n;

    rstd_sync #(.STAGES(SYNC_STAGES)) u_root_sync (
        .clk    (cfg_clk),
        .arst_n (root_rst_n),
        .srst_n (root_srst_n)
    );

    assign pll_pd = ~root_srst_n;

    rstd_hold #(.HOLD_CYC(HOLD_CYC)) u_root_hold (
        .clk    (cfg_clk),
        .srst_n (root_srst_n),
        .rst_o  (shared_rst)
    );

    // per-lane domains
    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        logic comb_n;
        logic cfg_srst_n;
        logic dp_srst_n;
        logic stretch_busy;

        assign comb_n = root_rst_n & lane_rst_n[ln];

        rstd_sync #(.STAGES(SYNC_STAGES)) u_cfg_sync (
            .clk    (cfg_clk),
            .arst_n (comb_n),
            .srst_n (cfg_srst_n)
        );

        rstd_hold #(.HOLD_CYC(HOLD_CYC)) u_cfg_hold (
            .clk    (cfg_clk),
            .srst_n (cfg_srst_n),
            .rst_o  (lane_cfg_rst[ln])
        );

        rstd_sync #(.STAGES(SYNC_STAGES)) u_dp_sync (
            .clk    (dp_clk[ln]),
            .arst_n (comb_n),
            .srst_n (dp_srst_n)
        );

        rstd_hold #(.HOLD_CYC(HOLD_CYC)) u_dp_hold (
            .clk    (dp_clk[ln]),
            .srst_n (dp_srst_n),
            .rst_o  (lane_dp_rst[ln])
        );

        rstd_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
            .clk    (cfg_clk),
            .arst   (lane_cfg_rst[ln]),
            .strobe (reconf_done[ln]),
            .busy   (stretch_busy)
        );

        assign lane_xcvr_rst[ln] = lane_cfg_rst[ln] | stretch_busy;
    end

    // R7: with the root released, nothing raises the PLL power-down
    p_pll_root_only_r7: assert property (@(posedge cfg_clk) disable iff (!root_rst_n)
        !$rose(pll_pd))
        else $error("pll_pd raised without root reset");

endmodule

// File: tb/tb_rst_fanout_ctrl.sv
`timescale 1ns/1ps
module tb_rst_fanout_ctrl;

    localparam int NL    = 4;
    localparam int SYNC  = 2;
    localparam int HOLD  = 8;
    localparam int STRT  = 8;

    logic          cfg_clk = 1'b0;
    logic [NL-1:0] dp_clk;
    logic          root_rst_n = 1'b1;
    logic [NL-1:0] lane_rst_n = '1;
    logic [NL-1:0] reconf_done = '0;
    logic          shared_rst, pll_pd;
    logic [NL-1:0] lane_cfg_rst, lane_dp_rst, lane_xcvr_rst;

    int n_chk  = 0;
    int n_fail = 0;
    int dp_edges [NL];

    always #2.5 cfg_clk = ~cfg_clk;   // 200 MHz

    for (genvar g = 0; g < NL; g++) begin : g_clk
        logic c = 1'b0;
        always #(3 + g) c = ~c;
        assign dp_clk[g] = c;
        initial dp_edges[g] = 0;
        always @(posedge c) dp_edges[g] <= dp_edges[g] + 1;
    end

    rst_fanout_ctrl #(
        .NUM_LANES(NL), .SYNC_STAGES(SYNC), .HOLD_CYC(HOLD), .STRETCH_CYC(STRT)
    ) dut (
        .cfg_clk(cfg_clk), .dp_clk(dp_clk), .root_rst_n(root_rst_n),
        .lane_rst_n(lane_rst_n), .reconf_done(reconf_done),
        .shared_rst(shared_rst), .pll_pd(pll_pd), .lane_cfg_rst(lane_cfg_rst),
        .lane_dp_rst(lane_dp_rst), .lane_xcvr_rst(lane_xcvr_rst)
    );

    // expected-value helpers derived from the requirements
    function automatic int release_edge();
        return SYNC + HOLD;
    endfunction

    function automatic logic stretch_expected(int k, int last_p);
        return (last_p >= 0) && (k - last_p < STRT);
    endfunction

    task automatic chk(string req, logic [NL-1:0] act, logic [NL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // datapath release timing for one lane (R3)
    task automatic dp_release(int ln);
        int base;
        base = dp_edges[ln];
        wait (dp_edges[ln] == base + release_edge() - 1);
        #1 chk("R3 dp held", NL'(lane_dp_rst[ln]), NL'(1));
        wait (dp_edges[ln] == base + release_edge());
        #1 chk("R3 dp release", NL'(lane_dp_rst[ln]), NL'(0));
    endtask

    // configuration-side release timing after root release (R3, R7)
    task automatic cfg_release_root();
        for (int e = 1; e <= release_edge(); e++) begin
            @(posedge cfg_clk); #1;
            if (e == SYNC - 1) chk("R7 pll held", NL'(pll_pd), NL'(1));
            if (e == SYNC)     chk("R7 pll release", NL'(pll_pd), NL'(0));
            if (e == release_edge() - 1) begin
                chk("R3 shared held", NL'(shared_rst), NL'(1));
                chk("R3 cfg held", lane_cfg_rst, '1);
            end
            if (e == release_edge()) begin
                chk("R3 shared release", NL'(shared_rst), NL'(0));
                chk("R3 cfg release", lane_cfg_rst, '0);
                chk("R3 xcvr release", lane_xcvr_rst, '0);
            end
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        #2 root_rst_n = 1'b0;
        // R1: asynchronous assertion, before any clock edge
        #0.2;
        chk("R1 shared", NL'(shared_rst), NL'(1));
        chk("R1 pll", NL'(pll_pd), NL'(1));
        chk("R1 cfg", lane_cfg_rst, '1);
        chk("R1 dp", lane_dp_rst, '1);
        chk("R1 xcvr", lane_xcvr_rst, '1);
        repeat (6) @(posedge cfg_clk);
        #1 chk("R1 cfg held", lane_cfg_rst, '1);
        chk("R4 dp from root", lane_dp_rst, '1);

        // root release: R3 in every domain, R7 pll timing
        @(negedge cfg_clk);
        root_rst_n = 1'b1;
        fork
            cfg_release_root();
            dp_release(0);
            dp_release(1);
            dp_release(2);
            dp_release(3);
        join
        repeat (4) @(posedge cfg_clk);

        // R2 / R4: single-lane reset isolation
        for (int t = 0; t < 3; t++) begin
            int ln;
            logic [NL-1:0] m;
            ln = $urandom % NL;
            m  = NL'(1) << ln;
            @(negedge cfg_clk);
            lane_rst_n[ln] = 1'b0;
            #0.5;
            chk("R2 cfg lane", lane_cfg_rst, m);
            chk("R4 dp lane", lane_dp_rst, m);
            chk("R2 xcvr lane", lane_xcvr_rst, m);
            chk("R2 shared untouched", NL'(shared_rst), NL'(0));
            chk("R7 pll untouched", NL'(pll_pd), NL'(0));
            repeat (3 + ($urandom % 5)) @(posedge cfg_clk);
            #1 chk("R2 cfg lane held", lane_cfg_rst, m);
            @(negedge cfg_clk);
            lane_rst_n[ln] = 1'b1;
            fork
                begin
                    for (int e = 1; e <= release_edge(); e++) begin
                        @(posedge cfg_clk); #1;
                        if (e == release_edge() - 1) chk("R3 lane cfg held", lane_cfg_rst, m);
                        if (e == release_edge())     chk("R3 lane cfg release", lane_cfg_rst, '0);
                    end
                end
                dp_release(ln);
            join
            chk("R2 pll after lane", NL'(pll_pd), NL'(0));
            repeat (3) @(posedge cfg_clk);
        end

        // R8: strobe during lane reset is ignored
        @(negedge cfg_clk);
        lane_rst_n[2] = 1'b0;
        repeat (2) @(negedge cfg_clk);
        reconf_done[2] = 1'b1;
        @(negedge cfg_clk);
        reconf_done[2] = 1'b0;
        lane_rst_n[2] = 1'b1;
        for (int e = 1; e <= release_edge() + 4; e++) begin
            @(posedge cfg_clk); #1;
            if (e == release_edge() - 1) chk("R8 xcvr with cfg", NL'(lane_xcvr_rst[2]), NL'(1));
            if (e >= release_edge())     chk("R8 strobe ignored", NL'(lane_xcvr_rst[2]), NL'(0));
        end

        // R5: directed single strobe on the highest lane
        @(negedge cfg_clk);
        reconf_done[NL-1] = 1'b1;
        @(posedge cfg_clk); #1;
        chk("R5 stretch starts", lane_xcvr_rst, NL'(1) << (NL-1));
        reconf_done[NL-1] = 1'b0;
        for (int k = 1; k <= STRT + 1; k++) begin
            @(posedge cfg_clk); #1;
            chk("R5 stretch width", lane_xcvr_rst,
                stretch_expected(k, 0) ? (NL'(1) << (NL-1)) : '0);
        end

        // R5 / R6: random strobe trains with retrigger
        for (int run = 0; run < 6; run++) begin
            int ln, last_p;
            logic p;
            ln = $urandom % NL;
            last_p = -1;
            for (int k = 0; k < 40; k++) begin
                @(negedge cfg_clk);
                p = (($urandom % 6) == 0) && (k < 30);
                reconf_done = p ? (NL'(1) << ln) : '0;
                @(posedge cfg_clk);
                if (p) last_p = k;
                #1;
                chk("R5 random stretch", lane_xcvr_rst,
                    stretch_expected(k, last_p) ? (NL'(1) << ln) : '0);
                chk("R6 cfg untouched", lane_cfg_rst, '0);
                chk("R6 dp untouched", lane_dp_rst, '0);
            end
            @(negedge cfg_clk);
            reconf_done = '0;
        end

        // R1: root reset in the middle of a stretch
        @(negedge cfg_clk);
        reconf_done[0] = 1'b1;
        @(negedge cfg_clk);
        reconf_done[0] = 1'b0;
        repeat (2) @(posedge cfg_clk);
        @(negedge cfg_clk);
        root_rst_n = 1'b0;
        #0.5;
        chk("R1 xcvr on root", lane_xcvr_rst, '1);
        chk("R1 dp on root", lane_dp_rst, '1);
        chk("R1 pll on root", NL'(pll_pd), NL'(1));
        chk("R1 shared on root", NL'(shared_rst), NL'(1));

        summary();
        $finish;
    end

endmodule